// File: doc/BRIEF.md
# Push/Pop Stack-Frame Micro-Op Sequencer

This block takes one 16-bit compressed stack-frame instruction and turns it into a sequence of single-register memory operations. There are four forms: push, pop, pop-and-return, and pop-zero-and-return. A 4-bit list field picks a register set: the return address plus a run of saved registers. A 2-bit field asks for extra stack space. The block works out the frame size from these two fields and the selected register width. It then issues one load or store per register, writes the new stack pointer, and for the return forms zeroes a0 and requests a jump through ra.

Instructions enter on a valid/ready handshake. In_ready is high only while the sequencer is idle. The instruction word, width select, reduced-register flag and stack pointer are all captured at the accepting edge and may change afterwards.

Micro-ops leave on a second valid/ready stream. While uop_ready is low, uop_valid stays high and every micro-op field holds its value. Exactly one micro-op completes on each cycle where uop_valid and uop_ready are both high. The stack-pointer write, the a0-zero write, the return request and the illegal flag are plain one-cycle pulses with no handshake.

Top module: `sfs_seq`

## Requirements
- R1: An instruction is recognised only when bits [15:13]=101, [12:11]=11, [8]=0 and [1:0]=10. Bits [10:9] then select the form: 00 push, 01 pop, 10 pop-zero-return, 11 pop-return. Any other word is illegal.
- R2: When the list field (bits [7:4]) is below 4, the instruction is illegal. An illegal instruction raises `illegal` for exactly one cycle, in the cycle after it is accepted. It produces no micro-op, no stack-pointer write, no a0 write and no return, and the block returns to idle in the next cycle.
- R3: When `rve` is high, a list value above 6 is also illegal.
- R4: List value L selects ra first, followed by saved registers s0 upward. The count is L-3 registers for L in 4..14, and 13 registers (ra and s0..s11) for L=15. The micro-ops are issued in that order.
- R5: Saved register i maps to index 8+i when i<2 and to 16+i otherwise. Ra is index 1.
- R6: Let W be 4 bytes in 32-bit mode and 8 bytes in 64-bit mode, and let N be the register count. The adjustment is (N·W rounded up to a multiple of 16) plus bits [3:2]·16.
- R7: Push issues a store (`uop_store`=1) for the k-th selected register (k from 0) at old_sp−(k+1)·W. After the last store it writes old_sp−adjustment to the stack pointer.
- R8: Pop issues a load (`uop_store`=0) for the k-th register at old_sp+adjustment−(k+1)·W. After the last load it writes old_sp+adjustment to the stack pointer.
- R9: After the stack-pointer write, pop-zero-return pulses `a0_zero_we` and then, in the next cycle, `ret_req`. Pop-return pulses only `ret_req`. Push and pop pulse neither.
- R10: `in_ready` is high only when idle. While `uop_valid` is high and `uop_ready` is low, the micro-op holds its value, and every accepted micro-op is handed over exactly once.
- R11: `uop_dw` is 1 in 64-bit mode and 0 in 32-bit mode. In 32-bit mode only `sp_in[31:0]` is used, and every address and stack-pointer result wraps modulo 2^32 with the upper bits at zero.
- R12: After reset, `in_ready` is high and every output event is low. At most one of `uop_valid`, `sp_we`, `a0_zero_we`, `ret_req` and `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction accepted this cycle if valid |
| in_insn | input | 16 | Compressed instruction word |
| xlen64 | input | 1 | 1 selects 64-bit registers, 0 selects 32-bit |
| rve | input | 1 | Reduced register file active |
| sp_in | input | XW | Current stack pointer |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Memory side takes the micro-op |
| uop_store | output | 1 | 1 store, 0 load |
| uop_dw | output | 1 | 1 eight-byte access, 0 four-byte access |
| uop_reg | output | 5 | Architectural register index |
| uop_addr | output | XW | Byte address of the slot |
| sp_we | output | 1 | Stack-pointer write pulse |
| sp_wdata | output | XW | New stack pointer value |
| a0_zero_we | output | 1 | Write zero to a0 |
| ret_req | output | 1 | Jump to ra |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The assertions check several rules on every cycle. An illegal pulse stands alone and is followed by idle. A micro-op stalled by back-pressure holds its value. No instruction is taken while the sequence runs. Events never overlap. The a0 write is always followed by the return. Every micro-op names ra or a saved register.

Other behaviour depends on the whole instruction and only the bench's scenarios can show it: the register count, the slot addresses, the frame arithmetic and the 32-bit wrap. The bench sweeps every form, list value, extra-space value, width and reduced-register setting under periodic back-pressure, together with corrupted encodings.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int INSN_W = 16;
  localparam int RL_W   = 4;
  localparam int REG_W  = 5;
  localparam int ADJ_W  = 8;
  localparam int CNT_W  = RL_W;

  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_POPZRET = 2'd2,
    OP_POPRET  = 2'd3
  } sfs_op_e;

  typedef struct packed {
    logic             legal;
    sfs_op_e          op;
    logic [CNT_W-1:0] nregs;
    logic [ADJ_W-1:0] adj;
  } sfs_dec_t;

  // slot 0 is ra; slot k>0 is saved register k-1
  function automatic logic [REG_W-1:0] slot_reg(input logic [CNT_W-1:0] k);
    logic [REG_W-1:0] kk;
    kk = REG_W'(k);
    if (k == '0)               return REG_W'(1);
    else if (k < CNT_W'(3))    return kk + REG_W'(7);
    else                       return kk + REG_W'(15);
  endfunction
endpackage

// File: rtl/sfs_decode.sv
module sfs_decode
  import sfs_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              x64,
  input  logic              rve,
  output sfs_dec_t          dec
);
  logic [RL_W-1:0]  rlist;
  logic [6:0]       raw_bytes;
  logic [ADJ_W-1:0] base;
  logic             enc_ok;

  always_comb begin
    rlist     = insn[7:4];
    enc_ok    = (insn[15:13] == 3'b101) && (insn[12:11] == 2'b11) &&
                !insn[8] && (insn[1:0] == 2'b10);
    dec.op    = sfs_op_e'(insn[10:9]);
    dec.nregs = (rlist == 4'd15) ? CNT_W'(13) : rlist - 4'd3;
    raw_bytes = x64 ? {dec.nregs, 3'b000} : {1'b0, dec.nregs, 2'b00};
    base      = (ADJ_W'(raw_bytes) + ADJ_W'(15)) & ADJ_W'(8'hF0);
    dec.adj   = base + {2'b00, insn[3:2], 4'b0000};
    dec.legal = enc_ok && (rlist >= 4'd4) && !(rve && (rlist > 4'd6));
  end
endmodule

// File: rtl/sfs_slot_gen.sv
module sfs_slot_gen
  import sfs_pkg::*;
#(
  parameter int XW = 64
) (
  input  logic [CNT_W-1:0] idx,
  input  logic [XW-1:0]    top,
  input  logic             x64,
  output logic [XW-1:0]    addr,
  output logic [REG_W-1:0] rnum
);
  localparam logic [XW-1:0] MASK32 = XW'(33'h0_FFFF_FFFF);

  logic [7:0]    slot;
  logic [XW-1:0] off;

  always_comb begin
    slot = 8'(idx) + 8'd1;
    off  = x64 ? XW'({slot, 3'b000}) : XW'({slot, 2'b00});
    addr = (top - off) & (x64 ? {XW{1'b1}} : MASK32);
    rnum = slot_reg(idx);
  end
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int XW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             xlen64,
  input  logic [XW-1:0]    sp_in,
  input  sfs_dec_t         dec,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic             uop_store,
  output logic             x64_q,
  output logic [CNT_W-1:0] idx_q,
  output logic [XW-1:0]    top_q,
  output logic             sp_we,
  output logic [XW-1:0]    sp_wdata,
  output logic             a0_zero_we,
  output logic             ret_req,
  output logic             illegal
);
  localparam logic [XW-1:0] MASK32 = XW'(33'h0_FFFF_FFFF);

  typedef enum logic [2:0] {S_IDLE, S_MEM, S_SP, S_ZERO, S_RET, S_ILL} st_e;

  st_e              st;
  sfs_op_e          op_q;
  logic [CNT_W-1:0] n_q;
  logic [XW-1:0]    nsp_q;
  logic [XW-1:0]    sp_eff, sp_new;
  logic             last;

  always_comb begin
    sp_eff = xlen64 ? sp_in : (sp_in & MASK32);
    sp_new = ((dec.op == OP_PUSH) ? sp_eff - XW'(dec.adj) : sp_eff + XW'(dec.adj))
             & (xlen64 ? {XW{1'b1}} : MASK32);
    last   = (idx_q == n_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= OP_PUSH;
      n_q   <= '0;
      idx_q <= '0;
      top_q <= '0;
      nsp_q <= '0;
      x64_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          if (!dec.legal) st <= S_ILL;
          else begin
            st    <= S_MEM;
            op_q  <= dec.op;
            n_q   <= dec.nregs;
            idx_q <= '0;
            x64_q <= xlen64;
            nsp_q <= sp_new;
            top_q <= (dec.op == OP_PUSH) ? sp_eff : sp_new;
          end
        end
        S_MEM: if (uop_ready) begin
          if (last) begin
            st    <= S_SP;
            idx_q <= '0;
          end else idx_q <= idx_q + CNT_W'(1);
        end
        S_SP: begin
          case (op_q)
            OP_POPZRET: st <= S_ZERO;
            OP_POPRET:  st <= S_RET;
            default:    st <= S_IDLE;
          endcase
        end
        S_ZERO: st <= S_RET;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    in_ready   = (st == S_IDLE);
    uop_valid  = (st == S_MEM);
    uop_store  = (op_q == OP_PUSH);
    sp_we      = (st == S_SP);
    sp_wdata   = nsp_q;
    a0_zero_we = (st == S_ZERO);
    ret_req    = (st == S_RET);
    illegal    = (st == S_ILL);
  end
endmodule

// File: rtl/sfs_seq.sv
module sfs_seq
  import sfs_pkg::*;
#(
  parameter int XW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_insn,
  input  logic             xlen64,
  input  logic             rve,
  input  logic [XW-1:0]    sp_in,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic             uop_store,
  output logic             uop_dw,
  output logic [4:0]       uop_reg,
  output logic [XW-1:0]    uop_addr,
  output logic             sp_we,
  output logic [XW-1:0]    sp_wdata,
  output logic             a0_zero_we,
  output logic             ret_req,
  output logic             illegal
);
  sfs_dec_t         dec;
  logic             x64_q;
  logic [CNT_W-1:0] idx_q;
  logic [XW-1:0]    top_q;

  sfs_decode u_dec (
    .insn (in_insn),
    .x64  (xlen64),
    .rve  (rve),
    .dec  (dec)
  );

  sfs_ctrl #(.XW(XW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .xlen64     (xlen64),
    .sp_in      (sp_in),
    .dec        (dec),
    .uop_valid  (uop_valid),
    .uop_ready  (uop_ready),
    .uop_store  (uop_store),
    .x64_q      (x64_q),
    .idx_q      (idx_q),
    .top_q      (top_q),
    .sp_we      (sp_we),
    .sp_wdata   (sp_wdata),
    .a0_zero_we (a0_zero_we),
    .ret_req    (ret_req),
    .illegal    (illegal)
  );

  sfs_slot_gen #(.XW(XW)) u_slot (
    .idx  (idx_q),
    .top  (top_q),
    .x64  (x64_q),
    .addr (uop_addr),
    .rnum (uop_reg)
  );

  assign uop_dw = x64_q;
endmodule

// File: rtl/sfs_seq_chk.sv
module sfs_seq_chk #(
  parameter int XW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          uop_valid,
  input logic          uop_ready,
  input logic          uop_store,
  input logic [4:0]    uop_reg,
  input logic [XW-1:0] uop_addr,
  input logic          sp_we,
  input logic          a0_zero_we,
  input logic          ret_req,
  input logic          illegal
);
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!uop_valid && !sp_we && !a0_zero_we && !ret_req)) else $error("illegal side effect"); // R2
  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> in_ready) else $error("no idle after illegal"); // R2
  AST_UOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_addr) && $stable(uop_reg) && $stable(uop_store)))
    else $error("stalled micro-op changed"); // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> !in_ready) else $error("ready while busy"); // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({uop_valid, sp_we, a0_zero_we, ret_req, illegal})) else $error("events overlap"); // R12
  AST_ZERO_THEN_RET: assert property (@(posedge clk) disable iff (!rst_n)
    a0_zero_we |=> ret_req) else $error("return missing after a0 zero"); // R9
  AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> (uop_reg == 5'd1 || uop_reg == 5'd8 || uop_reg == 5'd9 ||
                   (uop_reg >= 5'd18 && uop_reg <= 5'd27))) else $error("bad register"); // R5
endmodule

bind sfs_seq sfs_seq_chk #(.XW(XW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .uop_valid  (uop_valid),
  .uop_ready  (uop_ready),
  .uop_store  (uop_store),
  .uop_reg    (uop_reg),
  .uop_addr   (uop_addr),
  .sp_we      (sp_we),
  .a0_zero_we (a0_zero_we),
  .ret_req    (ret_req),
  .illegal    (illegal)
);

// File: tb/tb_sfs_seq.sv
`timescale 1ns/1ps
module tb_sfs_seq;
  localparam int XW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   in_insn = '0;
  logic          xlen64 = 1'b0;
  logic          rve = 1'b0;
  logic [XW-1:0] sp_in = '0;
  logic          uop_valid;
  logic          uop_ready = 1'b1;
  logic          uop_store;
  logic          uop_dw;
  logic [4:0]    uop_reg;
  logic [XW-1:0] uop_addr;
  logic          sp_we;
  logic [XW-1:0] sp_wdata;
  logic          a0_zero_we;
  logic          ret_req;
  logic          illegal;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  sfs_seq #(.XW(XW)) dut (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    #1 uop_ready = ((cyc % 3) != 0);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic int exp_reg(input int k);
    if (k == 0) return 1;
    if (k - 1 < 2) return 8 + k - 1;
    return 16 + k - 1;
  endfunction

  task automatic run_one(input logic [15:0] insn, input bit x64, input bit e, input logic [63:0] sp);
    int rl, op, n, w, adj, ku;
    bit enc, legal, push;
    string lreq;
    logic [63:0] mask, spm, top, nsp, a;
    int g_sp, g_a0, g_ret, g_ill;
    bit held, ord_ok;
    logic [63:0] h_addr;
    logic [4:0]  h_reg;

    rl   = int'(insn[7:4]);
    op   = int'(insn[10:9]);
    enc  = (insn[15:13] == 3'b101) && (insn[12:11] == 2'b11) && !insn[8] && (insn[1:0] == 2'b10);
    legal = enc && rl >= 4 && !(e && rl > 6);
    lreq = !enc ? "R1" : (rl < 4 ? "R2" : "R3");
    push = (op == 0);
    n    = (rl == 15) ? 13 : rl - 3;
    w    = x64 ? 8 : 4;
    adj  = ((n * w + 15) / 16) * 16 + int'(insn[3:2]) * 16;
    mask = x64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    spm  = sp & mask;
    nsp  = (push ? spm - 64'(adj) : spm + 64'(adj)) & mask;
    top  = push ? spm : nsp;

    in_insn = insn; xlen64 = x64; rve = e; sp_in = sp; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0; sp_in = ~sp; in_insn = ~insn;

    ku = 0; g_sp = 0; g_a0 = 0; g_ret = 0; g_ill = 0; held = 0; ord_ok = 1;
    h_addr = '0; h_reg = '0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if ($countones({uop_valid, sp_we, a0_zero_we, ret_req, illegal}) > 1) ord_ok = 0;
      if (held) chk(uop_valid && uop_addr == h_addr && uop_reg == h_reg, "R10 stall hold",
                    uop_addr, h_addr);
      held = 0;
      if (uop_valid) begin
        if (!uop_ready) begin
          held = 1; h_addr = uop_addr; h_reg = uop_reg;
        end else if (ku < n && legal) begin
          a = (top - 64'((ku + 1) * w)) & mask;
          chk(uop_reg == 5'(exp_reg(ku)), "R4/R5 register", 64'(uop_reg), 64'(exp_reg(ku)));
          chk(uop_addr == a, push ? "R7 store addr" : "R8 load addr", uop_addr, a);
          chk(uop_store == push, push ? "R7 store kind" : "R8 load kind", 64'(uop_store), 64'(push));
          chk(uop_dw == x64, "R11 size", 64'(uop_dw), 64'(x64));
          ku++;
        end else begin
          ku++;
        end
      end
      if (sp_we) begin
        if (ku != n) ord_ok = 0;
        chk(sp_wdata == nsp, push ? "R7 sp" : "R8 sp", sp_wdata, nsp);
        g_sp++;
      end
      if (a0_zero_we) begin
        if (g_sp != 1) ord_ok = 0;
        g_a0++;
      end
      if (ret_req) begin
        if (g_sp != 1 || (op == 2 && g_a0 != 1)) ord_ok = 0;
        g_ret++;
      end
      if (illegal) g_ill++;
      if (in_ready) break;
    end

    chk(in_ready, "R10 idle after sequence", 64'(in_ready), 64'd1);
    if (legal) begin
      chk(ku == n, "R4 count", 64'(ku), 64'(n));
      chk(g_sp == 1 && g_ill == 0, "R6 sp write once", 64'(g_sp), 64'd1);
      chk(g_a0 == (op == 2 ? 1 : 0), "R9 a0 zero", 64'(g_a0), 64'(op == 2));
      chk(g_ret == (op >= 2 ? 1 : 0), "R9 return", 64'(g_ret), 64'(op >= 2));
      chk(ord_ok, "R12 ordering", 64'(ord_ok), 64'd1);
    end else begin
      chk(g_ill == 1 && ku == 0 && g_sp == 0 && g_a0 == 0 && g_ret == 0, lreq,
          64'({g_ill[3:0], ku[3:0], g_sp[3:0], g_ret[3:0]}), 64'h1000);
    end
  endtask

  initial begin
    int k;
    logic [15:0] insn;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !uop_valid && !sp_we && !a0_zero_we && !ret_req && !illegal, "R12 reset",
        64'({in_ready, uop_valid, sp_we, a0_zero_we, ret_req, illegal}), 64'h20);

    k = 0;
    for (int op = 0; op < 4; op++)
      for (int rl = 0; rl < 16; rl++)
        for (int si = 0; si < 4; si++)
          for (int x = 0; x < 2; x++)
            for (int e = 0; e < 2; e++) begin
              insn = {3'b101, 2'b11, 2'(op), 1'b0, 4'(rl), 2'(si), 2'b10};
              run_one(insn, x[0], e[0], 64'hA5A5_0000_0000_0100 + 64'(k * 16));
              k++;
            end

    // corrupted encodings (R1)
    foreach (insn[b]) begin
      if (b == 15 || b == 14 || b == 13 || b == 12 || b == 11 || b == 8 || b == 1 || b == 0) begin
        insn = {3'b101, 2'b11, 2'b00, 1'b0, 4'd5, 2'b00, 2'b10};
        insn[b] = ~insn[b];
        run_one(insn, 1'b0, 1'b0, 64'h200);
      end
    end

    // 32-bit wrap (R11)
    run_one({3'b101, 2'b11, 2'b00, 1'b0, 4'd4, 2'b00, 2'b10}, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0008);
    run_one({3'b101, 2'b11, 2'b01, 1'b0, 4'd15, 2'b11, 2'b10}, 1'b0, 1'b0, 64'h0000_0001_FFFF_FFC0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule